// File: doc/BRIEF.md
# Reserved Instruction Exception Unit

This block sits beside the decode stage of a 32-bit core that mixes 16-bit and 32-bit instructions. Each cycle it looks at the opcode field of the decoded instruction and compares it with a table of reserved encodings. The table is a set of mask and match pairs given as parameters. When the opcode matches, the instruction is stopped before it executes. The block then redirects fetch to a fixed handler vector and flushes the younger instructions in the same cycle.

On entry, the unit copies the mode, interrupt-enable and carry bits of the status word into a backup status word. It clears interrupt-enable and carry and leaves the mode bit as it is. It stores the exact address of the faulting instruction in a backup PC, so bit 1 of that register tells whether the fault was on the second halfword of a word. The unit also settles a clash with an external interrupt request in the same cycle, and it takes an interrupt with the same entry sequence when the request is not pre-empted.

The return-from-exception path restores the status bits from their backups. It resumes at the backup PC with its two low bits cleared, so a fault at a halfword offset resumes at the start of its word.

Top module: `rie_unit`

## Requirements
- R1: Only instruction bits [31:24] are checked. With the default table, an opcode is reserved when it is 0x70 to 0x7F, 0x3C to 0x3F, 0xA5 or 0xFF. Every other bit of the instruction has no effect on the result.
- R2: A valid reserved instruction drives exec_o low, and a status write requested with it (psw_we_i) leaves psw_o unchanged.
- R3: An interrupt is taken (irq_take_o) only when ext_irq_i is high, psw_o bit 1 is set and the valid instruction is not reserved. If a reserved instruction and an interrupt request arrive in the same cycle, the exception is taken and irq_take_o stays low.
- R4: On any exception or interrupt entry, bpsw_o takes the value that psw_o held before the entry. Bit 2 is the mode bit, bit 1 is interrupt-enable and bit 0 is carry.
- R5: After entry, psw_o bit 2 is unchanged and bits 1 and 0 are 0.
- R6: On entry, bpc_o takes the full address of the instruction (dec_pc_i), including bit 1.
- R7: When a reserved instruction is taken, redirect_o and flush_o are high in that cycle and redirect_pc_o equals RIE_VEC (default 0x40). When an interrupt is taken, redirect_pc_o equals IRQ_VEC (default 0x80).
- R8: A valid return instruction (rte_i) that is neither reserved nor pre-empted raises redirect_o and flush_o. Its redirect_pc_o equals bpc_o with bits [1:0] forced to 0.
- R9: A return loads psw_o from bpsw_o. A non-reserved, non-pre-empted instruction with psw_we_i loads psw_o from psw_wd_i.
- R10: After reset, psw_o, bpsw_o and bpc_o are 0, and no redirect, flush or take output is active without a valid instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | Decoded instruction is valid this cycle |
| dec_insn_i | input | 32 | Decoded instruction word |
| dec_pc_i | input | 32 | Address of the decoded instruction |
| rte_i | input | 1 | Decoded instruction is a return from exception |
| psw_we_i | input | 1 | Instruction writes the status word |
| psw_wd_i | input | 3 | Status value written: {mode, ie, carry} |
| ext_irq_i | input | 1 | External interrupt request, level |
| exec_o | output | 1 | Instruction may execute |
| rie_take_o | output | 1 | Reserved instruction exception taken |
| irq_take_o | output | 1 | External interrupt taken |
| flush_o | output | 1 | Flush younger instructions |
| redirect_o | output | 1 | Fetch redirect valid |
| redirect_pc_o | output | 32 | Fetch redirect target |
| psw_o | output | 3 | Status word {mode, ie, carry} |
| bpsw_o | output | 3 | Backup status word |
| bpc_o | output | 32 | Backup PC |

## Verification
A reserved-instruction detection and an accepted external interrupt can fall in the same cycle. The bench first sets interrupt-enable through a status write. It then holds ext_irq_i high while it presents a reserved opcode. The result is judged on the take outputs, the vector and the backup contents. After the return restores interrupt-enable, the same request must be taken on the next ordinary instruction. Every one of the 256 opcode values is also swept with varied operand bits and with word-aligned and halfword-offset addresses, and each fault is followed by a return.

// File: rtl/rie_pkg.sv
`timescale 1ns/1ps
package rie_pkg;
  typedef struct packed {
    logic sm;
    logic ie;
    logic c;
  } psw_t;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_RIE  = 2'd1,
    EV_IRQ  = 2'd2,
    EV_RTE  = 2'd3
  } ev_e;
endpackage

// File: rtl/rie_opc_check.sv
`timescale 1ns/1ps
module rie_opc_check #(
  parameter int unsigned OPC_W   = 8,
  parameter int unsigned NUM_PAT = 4,
  parameter logic [NUM_PAT*OPC_W-1:0] MASK  = '0,
  parameter logic [NUM_PAT*OPC_W-1:0] MATCH = '0
) (
  input  logic [OPC_W-1:0] opc_i,
  output logic             hit_o
);
  logic [NUM_PAT-1:0] hit_vec;

  for (genvar g = 0; g < NUM_PAT; g++) begin : g_pat
    assign hit_vec[g] = ((opc_i & MASK[g*OPC_W +: OPC_W]) == MATCH[g*OPC_W +: OPC_W]);
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/rie_arbiter.sv
`timescale 1ns/1ps
module rie_arbiter
  import rie_pkg::*;
(
  input  logic valid_i,
  input  logic rsv_i,
  input  logic irq_i,
  input  logic ie_i,
  input  logic rte_i,
  output ev_e  ev_o,
  output logic exec_o
);
  logic irq_ok;
  assign irq_ok = irq_i & ie_i;

  // reserved > interrupt > return
  always_comb begin
    ev_o = EV_NONE;
    if (valid_i) begin
      if (rsv_i)       ev_o = EV_RIE;
      else if (irq_ok) ev_o = EV_IRQ;
      else if (rte_i)  ev_o = EV_RTE;
    end
  end

  assign exec_o = valid_i & ~rsv_i & ~irq_ok;
endmodule

// File: rtl/rie_state.sv
`timescale 1ns/1ps
module rie_state
  import rie_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ev_e           ev_i,
  input  logic          exec_i,
  input  logic          psw_we_i,
  input  psw_t          psw_wd_i,
  input  logic [AW-1:0] pc_i,
  output psw_t          psw_o,
  output psw_t          bpsw_o,
  output logic [AW-1:0] bpc_o
);
  psw_t          psw_q, bpsw_q;
  logic [AW-1:0] bpc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psw_q  <= '0;
      bpsw_q <= '0;
      bpc_q  <= '0;
    end else begin
      unique case (ev_i)
        EV_RIE, EV_IRQ: begin
          bpsw_q <= psw_q;
          psw_q  <= '{sm: psw_q.sm, ie: 1'b0, c: 1'b0};
          bpc_q  <= pc_i;
        end
        EV_RTE: psw_q <= bpsw_q;
        default: if (exec_i && psw_we_i) psw_q <= psw_wd_i;
      endcase
    end
  end

  assign psw_o  = psw_q;
  assign bpsw_o = bpsw_q;
  assign bpc_o  = bpc_q;
endmodule

// File: rtl/rie_unit.sv
`timescale 1ns/1ps
module rie_unit
  import rie_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned IW      = 32,
  parameter int unsigned OPC_MSB = 31,
  parameter int unsigned OPC_W   = 8,
  parameter int unsigned NUM_PAT = 4,
  parameter logic [NUM_PAT*OPC_W-1:0] RSV_MASK  = {8'hFC, 8'hFF, 8'hFF, 8'hF0},
  parameter logic [NUM_PAT*OPC_W-1:0] RSV_MATCH = {8'h3C, 8'hFF, 8'hA5, 8'h70},
  parameter logic [AW-1:0] RIE_VEC = 32'h0000_0040,
  parameter logic [AW-1:0] IRQ_VEC = 32'h0000_0080
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dec_valid_i,
  input  logic [IW-1:0] dec_insn_i,
  input  logic [AW-1:0] dec_pc_i,
  input  logic          rte_i,
  input  logic          psw_we_i,
  input  logic [2:0]    psw_wd_i,
  input  logic          ext_irq_i,
  output logic          exec_o,
  output logic          rie_take_o,
  output logic          irq_take_o,
  output logic          flush_o,
  output logic          redirect_o,
  output logic [AW-1:0] redirect_pc_o,
  output logic [2:0]    psw_o,
  output logic [2:0]    bpsw_o,
  output logic [AW-1:0] bpc_o
);
  localparam int unsigned OPC_LSB = OPC_MSB - OPC_W + 1;

  logic [OPC_W-1:0] opc;
  logic             rsv;
  ev_e              ev;
  logic             exec;
  psw_t             psw, bpsw;
  logic [AW-1:0]    bpc;
  logic             unused_operand;

  assign opc            = dec_insn_i[OPC_MSB:OPC_LSB];
  assign unused_operand = ^dec_insn_i[OPC_LSB-1:0];

  rie_opc_check #(
    .OPC_W  (OPC_W),
    .NUM_PAT(NUM_PAT),
    .MASK   (RSV_MASK),
    .MATCH  (RSV_MATCH)
  ) u_opc (
    .opc_i(opc),
    .hit_o(rsv)
  );

  rie_arbiter u_arb (
    .valid_i(dec_valid_i),
    .rsv_i  (rsv),
    .irq_i  (ext_irq_i),
    .ie_i   (psw.ie),
    .rte_i  (rte_i),
    .ev_o   (ev),
    .exec_o (exec)
  );

  rie_state #(.AW(AW)) u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (ev),
    .exec_i  (exec),
    .psw_we_i(psw_we_i),
    .psw_wd_i(psw_t'(psw_wd_i)),
    .pc_i    (dec_pc_i),
    .psw_o   (psw),
    .bpsw_o  (bpsw),
    .bpc_o   (bpc)
  );

  always_comb begin
    unique case (ev)
      EV_RIE:  redirect_pc_o = RIE_VEC;
      EV_IRQ:  redirect_pc_o = IRQ_VEC;
      EV_RTE:  redirect_pc_o = {bpc[AW-1:2], 2'b00};
      default: redirect_pc_o = '0;
    endcase
  end

  assign exec_o     = exec;
  assign rie_take_o = (ev == EV_RIE);
  assign irq_take_o = (ev == EV_IRQ);
  assign redirect_o = (ev != EV_NONE);
  assign flush_o    = (ev != EV_NONE);
  assign psw_o      = psw;
  assign bpsw_o     = bpsw;
  assign bpc_o      = bpc;
endmodule

// File: rtl/rie_unit_chk.sv
`timescale 1ns/1ps
module rie_unit_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dec_valid_i,
  input logic [AW-1:0] dec_pc_i,
  input logic          rte_i,
  input logic          ext_irq_i,
  input logic          exec_o,
  input logic          rie_take_o,
  input logic          irq_take_o,
  input logic          redirect_o,
  input logic [AW-1:0] redirect_pc_o,
  input logic [2:0]    psw_o,
  input logic [2:0]    bpsw_o,
  input logic [AW-1:0] bpc_o
);
  logic entry, ret;
  assign entry = rie_take_o | irq_take_o;
  assign ret   = dec_valid_i & rte_i & ~entry;

  a_r2_no_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rie_take_o |-> !exec_o);

  a_r3_rie_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rie_take_o && ext_irq_i) |-> !irq_take_o);

  a_r3_irq_needs_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |-> (psw_o[1] && ext_irq_i));

  a_r4_backup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry |=> (bpsw_o == $past(psw_o)));

  a_r5_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry |=> (psw_o[1:0] == 2'b00 && psw_o[2] == $past(psw_o[2])));

  a_r6_bpc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry |=> (bpc_o == $past(dec_pc_i)));

  a_r8_ret_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret |-> (redirect_o && redirect_pc_o == {bpc_o[AW-1:2], 2'b00}));

  a_r9_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret |=> (psw_o == $past(bpsw_o)));

  a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |-> (!redirect_o && !entry && !exec_o));
endmodule

bind rie_unit rie_unit_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_rie_unit.sv
`timescale 1ns/1ps
module sim_rie_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] insn = '0;
  logic [31:0] pc = '0;
  logic        rte = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  wd = '0;
  logic        irq = 1'b0;
  logic        exec_o, rie_o, irq_o, flush_o, redir_o;
  logic [31:0] rpc_o, bpc_o;
  logic [2:0]  psw_o, bpsw_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [2:0]  m_psw = '0;
  logic [2:0]  m_bpsw = '0;
  logic [31:0] m_bpc = '0;

  always #2.5 clk = ~clk;

  rie_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .dec_valid_i(valid), .dec_insn_i(insn),
    .dec_pc_i(pc), .rte_i(rte), .psw_we_i(we), .psw_wd_i(wd), .ext_irq_i(irq),
    .exec_o(exec_o), .rie_take_o(rie_o), .irq_take_o(irq_o), .flush_o(flush_o),
    .redirect_o(redir_o), .redirect_pc_o(rpc_o), .psw_o(psw_o),
    .bpsw_o(bpsw_o), .bpc_o(bpc_o)
  );

  function automatic bit is_rsv(input logic [7:0] op);
    return (op[7:4] == 4'h7) || (op[7:2] == 6'h0F) || (op == 8'hA5) || (op == 8'hFF);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [31:0] i, input logic [31:0] a,
                      input bit r, input bit w, input logic [2:0] d, input bit q);
    bit e_rie, e_irq, e_rte, e_exec, e_red;
    logic [31:0] e_pc;
    string tag;
    @(negedge clk);
    valid = v; insn = i; pc = a; rte = r; we = w; wd = d; irq = q;
    e_rie  = v && is_rsv(i[31:24]);
    e_irq  = v && !e_rie && q && m_psw[1];
    e_rte  = v && r && !e_rie && !e_irq;
    e_exec = v && !e_rie && !e_irq;
    e_red  = e_rie || e_irq || e_rte;
    e_pc   = e_rie ? 32'h40 : e_irq ? 32'h80 : e_rte ? {m_bpc[31:2], 2'b00} : 32'h0;
    tag = (e_rie && q) ? "R3 R7" : e_rie ? "R1 R7" : e_irq ? "R3 R7" : e_rte ? "R8" : "R1";
    #0.5;
    chk(tag, {60'd0, rie_o, irq_o, flush_o, redir_o}, {60'd0, e_rie, e_irq, e_red, e_red});
    chk(e_rie ? "R2" : "R1", {63'd0, exec_o}, {63'd0, e_exec});
    if (e_red) chk(tag, {32'd0, rpc_o}, {32'd0, e_pc});
    if (e_rie || e_irq) begin
      m_bpsw = m_psw; m_psw = {m_psw[2], 2'b00}; m_bpc = a;
      tag = "R2 R4 R5 R6";
    end else if (e_rte) begin
      m_psw = m_bpsw; tag = "R9";
    end else begin
      if (e_exec && w) m_psw = d;
      tag = "R9";
    end
    @(posedge clk);
    #0.5;
    chk(tag, {26'd0, psw_o, bpsw_o, bpc_o}, {26'd0, m_psw, m_bpsw, m_bpc});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #12;
    chk("R10", {26'd0, psw_o, bpsw_o, bpc_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk); #0.5;
    chk("R10", {60'd0, rie_o, irq_o, flush_o, redir_o}, 64'd0);

    // r1_ sweep over every opcode, operand bits varied, aligned and offset addresses
    for (int op = 0; op < 256; op++) begin
      logic [7:0] o = 8'(op);
      logic [2:0] pat = o[2:0] ^ 3'b101;
      step(1, 32'h0000_0000, 32'h200, 0, 1, pat, 0);
      step(1, {o, 8'(op * 37), 16'(op * 911)}, 32'h1000 + 32'(op * 4) + (o[0] ? 32'd2 : 32'd0),
           0, 1, ~pat, 0);
      if (is_rsv(o)) step(1, 32'h1000_0000, 32'h300, 1, 0, 3'b000, 0);
    end

    // R3 priority: enable interrupts, then reserved opcode with pending request
    step(1, 32'h0, 32'h400, 0, 1, 3'b111, 0);
    step(1, 32'hA500_1234, 32'h0006, 0, 0, 3'b000, 1);
    step(0, 32'h0, 32'h0, 0, 0, 3'b000, 1);
    step(1, 32'h1000_0000, 32'h500, 1, 0, 3'b000, 1);
    step(1, 32'h1000_0000, 32'h500, 1, 0, 3'b000, 0);
    // R3 interrupt accepted on an ordinary instruction once enabled again
    step(1, 32'h2000_0000, 32'h0000_0106, 0, 0, 3'b000, 1);
    step(1, 32'h1000_0000, 32'h600, 1, 0, 3'b000, 0);
    // R8 faults at 4 and 6 both resume at 4
    step(1, 32'h7000_0000, 32'h4, 0, 0, 3'b000, 0);
    step(1, 32'h1000_0000, 32'h700, 1, 0, 3'b000, 0);
    step(1, 32'h7F00_0000, 32'h6, 0, 0, 3'b000, 0);
    step(1, 32'h1000_0000, 32'h700, 1, 0, 3'b000, 0);
    step(0, 32'hFF00_0000, 32'h8, 1, 1, 3'b111, 1);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule